// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block hangs on an 8-bit peripheral bus and turns characters written by software into asynchronous serial frames on a single output line. It decodes two register locations through one select input. The control location takes the configuration, and reading it returns transmitter status. The data location takes the characters to send. Configuration follows a fixed order. After reset, the first control write sets the frame format: baud divisor, character length, parity and stop bits. Every later control write is a command. A command can enable the transmitter, or it can force an internal reset that returns the block to waiting for a new format word.

Characters go through a one-deep holding register into a shift register. Software polls the ready flag before each data write. The shift engine advances on a baud tick input: a one-cycle pulse in the system clock domain, issued at the chosen multiple of the line rate (for example 16 pulses per bit for 9600 baud). A new character can follow the stop bits of the previous one with no idle time between them.

Top module: `async_serial_tx`

## Requirements
- R1: A bus access with cs_n low selects the control/status location when cd is 1 and the data location when cd is 0. Reading the control location (rd_n low) returns the status byte. Reading the data location returns 00h.
- R2: After reset, the first control write is stored as the format word and every later control write is a command. A command with bit 6 set forces an internal reset: the transmitter is disabled, any held or partly sent character is dropped, the line goes high on the next clock, status reads 05h, and the next control write is a format word again.
- R3: Format bits [1:0] set the baud ticks per bit: 00 or 01 gives 1, 10 gives 16, 11 gives 64.
- R4: Format bits [3:2] set the character length to 5 + value bits. The low bits of the written byte are sent least significant bit first.
- R5: Format bit 4 enables a parity bit after the data bits. Format bit 5 selects even parity when 1 and odd parity when 0. Parity is computed over the sent data bits only.
- R6: Format bits [7:6] set the stop length: 00 or 01 gives one bit, 10 gives one and a half bits (half-bit tick counts rounded up), 11 gives two bits. Stop bits are high.
- R7: The line is high while idle. Each frame starts with one low start bit and then carries the data bits, the optional parity bit and the stop bits.
- R8: Status bit 0 (ready) is 1 when the holding register is empty. It drops to 0 when an accepted data write fills the register and returns to 1 when that character moves to the shift register.
- R9: Status bit 2 is 1 only when both the holding register and the shift register are empty. All other status bits read 0.
- R10: Command bit 0 enables the transmitter. A data write while the transmitter is disabled is discarded: it produces no frame, even after a later enable, and ready stays 1.
- R11: A character moves from the holding register to the shift register only on a baud tick, either when the shifter is idle or on the tick that ends the last stop bit. Back-to-back frames therefore follow each other with no idle gap.
- R12: After reset, the line is high, status reads 05h and the block waits for a format word.
- R13: A write strobe (cs_n and wr_n both low) held for several clocks counts as one write, taken in its first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at the baud-clock rate |
| cs_n | input | 1 | Chip select, active low |
| cd | input | 1 | Location select: 1 control/status, 0 data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Write data bus |
| dout | output | 8 | Read data bus |
| txd | output | 1 | Serial output line |

## Verification
The bench decodes every frame on the line with the format that was programmed, checks the start bit, data bits, parity and stop bits, and measures the start-to-start period of back-to-back frames. A wrong divisor or stop length changes that period. An added idle gap between frames lengthens it. A parity bit with the wrong sense shows up directly in the decoded frame. The ordering checks catch a design that keeps treating control writes as format words, or that sends a character written while disabled: either one produces a wrong or unexpected frame. A long write strobe checks for duplicated frames. An internal reset issued mid-frame must leave the line high and report status 05h at once.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int unsigned LEN_W = 4;
    localparam int unsigned FAC_W = 7;
    localparam int unsigned STP_W = 8;

    // decoded frame format used by the shift engine
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             par_even;
        logic [FAC_W-1:0] factor;
        logic [STP_W-1:0] stop_ticks;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_PAR,
        SH_STOP
    } sh_state_e;

    // turn a format word into tick counts and field values
    function automatic frame_cfg_t decode_mode(input logic [7:0] m);
        frame_cfg_t  c;
        int unsigned fac;
        int unsigned halves;
        case (m[1:0])
            2'b10:   fac = 16;
            2'b11:   fac = 64;
            default: fac = 1;
        endcase
        case (m[7:6])
            2'b10:   halves = 3;
            2'b11:   halves = 4;
            default: halves = 2;
        endcase
        c.len        = LEN_W'(32'd5 + 32'(m[3:2]));
        c.par_en     = m[4];
        c.par_even   = m[5];
        c.factor     = FAC_W'(fac);
        c.stop_ticks = STP_W'((halves * fac + 32'd1) / 32'd2);
        return c;
    endfunction

endpackage

// File: rtl/atx_regs.sv
module atx_regs #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cd,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] mode,
    output logic          txen,
    output logic          data_wr,
    output logic          soft_rst
);

    typedef struct packed {
        logic          wr_seen;
        logic          expect_mode;
        logic          txen;
        logic [DW-1:0] mode;
    } regs_t;

    regs_t q, d;
    logic  wr_act;
    logic  wr_pulse;

    always_comb begin
        d        = q;
        wr_act   = !cs_n && !wr_n;
        wr_pulse = wr_act && !q.wr_seen;
        d.wr_seen = wr_act;
        data_wr  = wr_pulse && !cd;
        soft_rst = wr_pulse && cd && !q.expect_mode && din[6];
        if (wr_pulse && cd) begin
            if (q.expect_mode) begin
                d.mode        = din;
                d.expect_mode = 1'b0;
            end else if (din[6]) begin
                d.expect_mode = 1'b1;
                d.txen        = 1'b0;
            end else begin
                d.txen = din[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{wr_seen: 1'b0, expect_mode: 1'b1, txen: 1'b0, mode: '0};
        end else begin
            q <= d;
        end
    end

    assign mode = q.mode;
    assign txen = q.txen;

    // internal reset re-arms the format word and disables sending
    assert_softreset_rearms_R2 : assert property (
        @(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q.expect_mode && !q.txen)
    ) else $error("internal reset did not re-arm format word");

endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic          en,
    input  logic [DW-1:0] din,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.full = 1'b0;
        end else begin
            if (take) begin
                d.full = 1'b0;
            end
            if (wr && en) begin
                d.full = 1'b1;
                d.data = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{full: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign full = q.full;
    assign data = q.data;

    assert_take_from_full_R11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        take |-> q.full
    ) else $error("transfer from empty holding register");

    assert_disabled_write_dropped_R10 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr && !en && !q.full) |=> !q.full
    ) else $error("write accepted while disabled");

endmodule

// File: rtl/atx_shift.sv
module atx_shift
    import atx_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          avail,
    input  logic [DW-1:0] hdata,
    output logic          take,
    output logic          busy,
    output logic          txd
);

    localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        sh_state_e     state;
        logic [DW-1:0] sh;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          par;
        logic          txd;
    } sh_regs_t;

    localparam sh_regs_t SH_RST = '{state: SH_IDLE, sh: '0, idx: '0,
                                    cnt: '0, par: 1'b0, txd: 1'b1};

    sh_regs_t      q, d;
    logic [CW-1:0] limit;
    logic          last_tick;
    logic          free;
    logic [DW-1:0] masked;

    always_comb begin
        d    = q;
        take = 1'b0;
        limit     = (q.state == SH_STOP) ? CW'(cfg.stop_ticks) : CW'(cfg.factor);
        last_tick = (q.cnt == limit - CW'(1));
        free      = (q.state == SH_IDLE) || ((q.state == SH_STOP) && last_tick);
        for (int i = 0; i < int'(DW); i++) begin
            masked[i] = hdata[i] && (i < int'(cfg.len));
        end
        if (clr) begin
            d = SH_RST;
        end else if (tick) begin
            if (free && avail) begin
                take    = 1'b1;
                d.state = SH_START;
                d.sh    = hdata;
                d.idx   = '0;
                d.cnt   = '0;
                d.par   = (^masked) ^ !cfg.par_even;
                d.txd   = 1'b0;
            end else if (q.state != SH_IDLE) begin
                if (last_tick) begin
                    d.cnt = '0;
                    case (q.state)
                        SH_START: begin
                            d.state = SH_DATA;
                            d.txd   = q.sh[0];
                        end
                        SH_DATA: begin
                            if (LEN_W'(q.idx) == cfg.len - LEN_W'(1)) begin
                                if (cfg.par_en) begin
                                    d.state = SH_PAR;
                                    d.txd   = q.par;
                                end else begin
                                    d.state = SH_STOP;
                                    d.txd   = 1'b1;
                                end
                            end else begin
                                d.idx = q.idx + IW'(1);
                                d.sh  = q.sh >> 1;
                                d.txd = q.sh[1];
                            end
                        end
                        SH_PAR: begin
                            d.state = SH_STOP;
                            d.txd   = 1'b1;
                        end
                        default: begin
                            d.state = SH_IDLE;
                            d.txd   = 1'b1;
                        end
                    endcase
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SH_RST;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != SH_IDLE);
    assign txd  = q.txd;

    assert_idle_line_high_R7 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (q.state == SH_IDLE) |-> q.txd
    ) else $error("line low while idle");

    assert_start_bit_low_R7 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (q.state == SH_START) |-> !q.txd
    ) else $error("start bit not low");

    assert_start_on_tick_R11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        ((q.state == SH_IDLE) && !tick) |=> (q.state == SH_IDLE)
    ) else $error("frame started without a baud tick");

endmodule

// File: rtl/async_serial_tx.sv
module async_serial_tx
    import atx_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          cs_n,
    input  logic          cd,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          txd
);

    logic [DW-1:0] mode;
    logic          txen;
    logic          data_wr;
    logic          soft_rst;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          take;
    logic          sh_busy;
    frame_cfg_t    cfg;
    logic          rd_status;
    logic [DW-1:0] status;

    atx_regs #(.DW(DW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .cd       (cd),
        .wr_n     (wr_n),
        .din      (din),
        .mode     (mode),
        .txen     (txen),
        .data_wr  (data_wr),
        .soft_rst (soft_rst)
    );

    atx_hold #(.DW(DW)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .wr    (data_wr),
        .en    (txen),
        .din   (din),
        .take  (take),
        .full  (hold_full),
        .data  (hold_data)
    );

    always_comb begin
        cfg = decode_mode(8'(mode));
    end

    atx_shift #(.DW(DW), .CW(CW)) shift_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .tick  (baud_tick),
        .cfg   (cfg),
        .avail (hold_full && txen),
        .hdata (hold_data),
        .take  (take),
        .busy  (sh_busy),
        .txd   (txd)
    );

    always_comb begin
        status    = '0;
        status[0] = !hold_full;
        status[2] = !hold_full && !sh_busy;
        rd_status = !cs_n && !rd_n && cd;
        dout      = rd_status ? status : '0;
    end

    // a frame may only begin from a filled holding register
    assert_frame_from_held_char_R11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> $past(hold_full)
    ) else $error("frame began without a held character");

endmodule

// File: tb/async_serial_tx_tb.sv
module async_serial_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cs_n = 1'b1;
    logic       cd = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       txd;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tdiv = 0;
    int n_frames = 0;
    int last_start = 0;
    int prev_start = 0;
    bit mon_skip = 1'b0;
    bit done = 1'b0;
    logic [7:0] cur_mode = 8'hCE;
    logic [7:0] expq[$];

    async_serial_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cs_n(cs_n),
        .cd(cd), .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 0);
    end

    function automatic int f_factor(input logic [7:0] m);
        case (m[1:0])
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 1;
        endcase
    endfunction

    function automatic int f_len(input logic [7:0] m);
        return 5 + int'(m[3:2]);
    endfunction

    function automatic int f_stop_ticks(input logic [7:0] m);
        int h;
        h = (m[7:6] == 2'b10) ? 3 : ((m[7:6] == 2'b11) ? 4 : 2);
        return (h * f_factor(m) + 1) / 2;
    endfunction

    function automatic int f_frame_clks(input logic [7:0] m);
        return (f_factor(m) * (1 + f_len(m) + int'(m[4])) + f_stop_ticks(m)) * TICK_DIV;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic c, input logic [7:0] v, input int hold = 1);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; cd = c; din = v;
        repeat (hold) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic c, output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; cd = c;
        #1 v = dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic wait_rdy();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(1'b1, s);
            if (s[0]) break;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(1'b1, s);
            if (s == 8'h05) break;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] v);
        expq.push_back(v);
        bus_wr(1'b0, v);
    endtask

    // frame decoder on the serial line
    initial begin
        logic prev;
        prev = 1'b1;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (prev && !txd) begin
                int b, l, sc;
                bit pe, ev, skip;
                logic [7:0] v, e, msk;
                logic p;
                b = f_factor(cur_mode) * TICK_DIV;
                l = f_len(cur_mode);
                pe = cur_mode[4]; ev = cur_mode[5]; sc = int'(cur_mode[7:6]);
                skip = mon_skip; mon_skip = 1'b0;
                prev_start = last_start; last_start = cyc; n_frames++;
                repeat (b / 2) @(negedge clk);
                if (!skip) chk(txd == 1'b0, "R7 start bit", int'(txd), 0);
                v = 8'h00;
                for (int i = 0; i < l; i++) begin
                    repeat (b) @(negedge clk);
                    v[i] = txd;
                end
                if (pe) begin
                    repeat (b) @(negedge clk);
                    p = txd;
                    if (!skip) chk(p == (ev ? ^v : ~^v), "R5 parity bit", int'(p), int'(ev ? ^v : ~^v));
                end
                repeat (b) @(negedge clk);
                if (!skip) chk(txd == 1'b1, "R6 stop bit", int'(txd), 1);
                if (sc == 3) begin
                    repeat (b) @(negedge clk);
                    if (!skip) chk(txd == 1'b1, "R6 second stop bit", int'(txd), 1);
                end
                if (!skip) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R10 unexpected frame", int'(v), 0);
                    end else begin
                        e = expq.pop_front();
                        msk = 8'((9'h1 << l) - 9'h1);
                        chk(v == (e & msk), "R4 data bits", int'(v), int'(e & msk));
                    end
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        int nf;
        void'($urandom(32'h5eed_0c1a));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state and location decode
        chk(txd == 1'b1, "R12 idle line", int'(txd), 1);
        bus_rd(1'b1, s);
        chk(s == 8'h05, "R12 status after reset", int'(s), 8'h05);
        bus_rd(1'b0, s);
        chk(s == 8'h00, "R1 data location read", int'(s), 0);

        // 8 bits, no parity, two stops, x16
        cur_mode = 8'hCE;
        bus_wr(1'b1, 8'hCE);
        bus_wr(1'b1, 8'h11);
        send(8'hA5);
        wait_rdy();
        send(8'h3C);
        bus_rd(1'b1, s);
        chk(s == 8'h00, "R8 R9 status while both full", int'(s), 0);
        wait_idle();
        chk(last_start - prev_start == f_frame_clks(8'hCE), "R3 R6 R11 frame period",
            last_start - prev_start, f_frame_clks(8'hCE));
        chk(expq.size() == 0, "R4 all frames seen", expq.size(), 0);

        // disabled transmitter discards data
        nf = n_frames;
        bus_wr(1'b1, 8'h00);
        bus_wr(1'b0, 8'h77);
        bus_rd(1'b1, s);
        chk(s == 8'h05, "R10 ready stays set", int'(s), 8'h05);
        bus_wr(1'b1, 8'h11);
        repeat (500) @(negedge clk);
        chk(n_frames == nf, "R10 no frame from dropped write", n_frames - nf, 0);

        // held write strobe yields one character
        expq.push_back(8'h5A);
        bus_wr(1'b0, 8'h5A, 6);
        wait_idle();
        chk(n_frames == nf + 1, "R13 one frame per strobe", n_frames - nf, 1);

        // internal reset in the middle of a frame
        mon_skip = 1'b1;
        bus_wr(1'b0, 8'hF0);
        repeat (100) @(negedge clk);
        bus_wr(1'b1, 8'h40);
        chk(txd == 1'b1, "R2 line high after internal reset", int'(txd), 1);
        bus_rd(1'b1, s);
        chk(s == 8'h05, "R2 status after internal reset", int'(s), 8'h05);
        repeat (450) @(negedge clk);

        // new format word: x1, 8 bits, 1.5 stops
        cur_mode = 8'h8D;
        bus_wr(1'b1, 8'h8D);
        bus_wr(1'b1, 8'h01);
        send(8'hC3);
        wait_rdy();
        send(8'h81);
        wait_rdy();
        send(8'h7E);
        wait_idle();
        chk(last_start - prev_start == f_frame_clks(8'h8D), "R2 R6 R11 reformatted period",
            last_start - prev_start, f_frame_clks(8'h8D));
        chk(expq.size() == 0, "R2 all frames seen", expq.size(), 0);

        // random formats and characters
        for (int k = 0; k < 10; k++) begin
            logic [7:0] m;
            m = 8'($urandom);
            bus_wr(1'b1, 8'h40);
            cur_mode = m;
            bus_wr(1'b1, m);
            bus_wr(1'b1, 8'h11);
            send(8'($urandom));
            wait_rdy();
            send(8'($urandom));
            wait_rdy();
            send(8'($urandom));
            wait_idle();
            chk(last_start - prev_start == f_frame_clks(m), "R3 R5 R6 random period",
                last_start - prev_start, f_frame_clks(m));
            chk(expq.size() == 0, "R4 random frames seen", expq.size(), 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule